// File: doc/BRIEF.md
# APB Level-Interrupt Aggregator

This block collects up to 64 level-sensitive interrupt request lines and merges them into one interrupt line for a parent controller. Each line has its own enable bit and its own mask bit. A line reaches the merged output only while its input is high, its enable bit is 1 and its mask bit is 0. Lines are grouped into a low word (lines 0 to 31) and a high word (lines 32 to 63). Each word has its own enable, mask and final-status register on an APB slave port.

The parameter `NUM_SRC` sets the number of lines, from 2 to 64. Control bits for lines that do not exist have no storage and always read 0. Software can find the line count by writing all ones to the enable registers and reading them back. When the merged line is high, software scans both final-status words to find the active lines.

Top module: `irq_aggr_apb`

## Requirements
- R1: After reset, enable and mask registers of both words read 0, both final-status words read 0, and `irq_o` is 0.
- R2: The enable register at byte offset 0x00 holds lines 0–31 (bit n = line n), and the one at 0x04 holds lines 32–63 (bit n = line 32+n). The implemented bits read back the last value written.
- R3: The mask register at 0x08 holds lines 0–31, and the one at 0x0C holds lines 32–63, with the same bit layout. The implemented bits read back the last value written. A mask bit of 1 blocks the line.
- R4: Enable and mask bits for line indices at or above `NUM_SRC` read 0, even after all ones are written.
- R5: Final status at 0x30 (lines 0–31) and 0x34 (lines 32–63) reads, per bit, input AND enable AND NOT mask. It follows the input level with no latching and is read-only.
- R6: `irq_o` is the OR of all final-status bits, registered. The value sampled at one rising edge appears after that edge, so a change at any input shows one cycle later.
- R7: Any byte address other than the six listed, including misaligned addresses, reads 0. A write to such an address changes no register.
- R8: Every transfer completes with no wait states: `pready_o` is 1 and `pslverr_o` is 0. Read data is valid throughout the setup and access phases of a read.
- R9: When `NUM_SRC` is 32 or less, every bit of the high-word enable, mask and final-status registers reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Transfer complete, always 1 |
| pslverr_o | output | 1 | Transfer error, always 0 |
| irq_src_i | input | NUM_SRC | Level interrupt request lines |
| irq_o | output | 1 | Merged interrupt, registered |

## Verification
The assertions assume the APB master follows the protocol: address and direction stay stable across the setup and access phases. They also assume the request lines change only between clock edges, so a final-status read can be compared with the lines in the same cycle. The bench drives every bus signal and line level on the falling edge. Each transfer holds setup for one cycle and access for one cycle, so the values seen at each rising edge are settled. The bench runs a second instance with 20 lines on the same bus, which covers the partly empty low word and the fully empty high word.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int WORD_W  = 32;
  localparam int MAX_SRC = 64;

  localparam logic [31:0] OFF_EN_LO  = 32'h00;
  localparam logic [31:0] OFF_EN_HI  = 32'h04;
  localparam logic [31:0] OFF_MSK_LO = 32'h08;
  localparam logic [31:0] OFF_MSK_HI = 32'h0C;
  localparam logic [31:0] OFF_ST_LO  = 32'h30;
  localparam logic [31:0] OFF_ST_HI  = 32'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_MSK_LO,
    SEL_MSK_HI,
    SEL_ST_LO,
    SEL_ST_HI
  } reg_sel_e;

  // full-address compare: misaligned accesses fall to SEL_NONE
  function automatic reg_sel_e addr_decode(input logic [31:0] a);
    case (a)
      OFF_EN_LO:  return SEL_EN_LO;
      OFF_EN_HI:  return SEL_EN_HI;
      OFF_MSK_LO: return SEL_MSK_LO;
      OFF_MSK_HI: return SEL_MSK_HI;
      OFF_ST_LO:  return SEL_ST_LO;
      OFF_ST_HI:  return SEL_ST_HI;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_aggr_bank.sv
module irq_aggr_bank #(
  parameter int CNT = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_we_i,
  input  logic        msk_we_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] src_i,
  output logic [31:0] en_o,
  output logic [31:0] msk_o,
  output logic [31:0] stat_o
);
  localparam logic [31:0] IMPL_W = (CNT >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT) - 32'd1);

  logic [31:0] en_q, msk_q;

  // constant-zero bits beyond CNT let synthesis drop those flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      msk_q <= '0;
    end else begin
      if (en_we_i)  en_q  <= wdata_i & IMPL_W;
      if (msk_we_i) msk_q <= wdata_i & IMPL_W;
    end
  end

  assign en_o   = en_q;
  assign msk_o  = msk_q;
  assign stat_o = src_i & en_q & ~msk_q & IMPL_W;
endmodule

// File: rtl/irq_aggr_rdmux.sv
module irq_aggr_rdmux
  import irq_aggr_pkg::*;
(
  input  logic        rd_en_i,
  input  reg_sel_e    sel_i,
  input  logic [31:0] en_lo_i,
  input  logic [31:0] en_hi_i,
  input  logic [31:0] msk_lo_i,
  input  logic [31:0] msk_hi_i,
  input  logic [31:0] st_lo_i,
  input  logic [31:0] st_hi_i,
  output logic [31:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (sel_i)
        SEL_EN_LO:  rdata_o = en_lo_i;
        SEL_EN_HI:  rdata_o = en_hi_i;
        SEL_MSK_LO: rdata_o = msk_lo_i;
        SEL_MSK_HI: rdata_o = msk_hi_i;
        SEL_ST_LO:  rdata_o = st_lo_i;
        SEL_ST_HI:  rdata_o = st_hi_i;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggr_combine.sv
module irq_aggr_combine #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggr_apb.sv
module irq_aggr_apb
  import irq_aggr_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [31:0]        pwdata_i,
  output logic [31:0]        prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic               irq_o
);
  localparam int NUM_WORDS = (NUM_SRC > WORD_W) ? 2 : 1;

  logic [31:0] addr_ext;
  reg_sel_e    sel;
  logic        wr_en, rd_en;

  logic [1:0][31:0] en_w, msk_w, st_w;
  logic [1:0]       en_we, msk_we;

  always_comb begin
    addr_ext = 32'(paddr_i);
    sel      = addr_decode(addr_ext);
  end

  assign wr_en = psel_i & penable_i & pwrite_i;
  assign rd_en = psel_i & ~pwrite_i;

  assign en_we[0]  = wr_en & (sel == SEL_EN_LO);
  assign en_we[1]  = wr_en & (sel == SEL_EN_HI);
  assign msk_we[0] = wr_en & (sel == SEL_MSK_LO);
  assign msk_we[1] = wr_en & (sel == SEL_MSK_HI);

  for (genvar w = 0; w < 2; w++) begin : g_word
    if (w < NUM_WORDS) begin : g_bank
      localparam int LO  = w * WORD_W;
      localparam int CNT = ((NUM_SRC - LO) > WORD_W) ? WORD_W : (NUM_SRC - LO);
      logic [31:0] src_w;
      assign src_w = 32'(irq_src_i[LO +: CNT]);

      irq_aggr_bank #(.CNT(CNT)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_we_i (en_we[w]),
        .msk_we_i(msk_we[w]),
        .wdata_i (pwdata_i),
        .src_i   (src_w),
        .en_o    (en_w[w]),
        .msk_o   (msk_w[w]),
        .stat_o  (st_w[w])
      );
    end else begin : g_empty
      assign en_w[w]  = '0;
      assign msk_w[w] = '0;
      assign st_w[w]  = '0;
    end
  end

  irq_aggr_rdmux u_rdmux (
    .rd_en_i (rd_en),
    .sel_i   (sel),
    .en_lo_i (en_w[0]),
    .en_hi_i (en_w[1]),
    .msk_lo_i(msk_w[0]),
    .msk_hi_i(msk_w[1]),
    .st_lo_i (st_w[0]),
    .st_hi_i (st_w[1]),
    .rdata_o (prdata_o)
  );

  irq_aggr_combine #(.N(64)) u_combine (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i({st_w[1], st_w[0]}),
    .irq_o (irq_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               psel_i,
  input logic               pwrite_i,
  input logic [ADDR_W-1:0]  paddr_i,
  input logic [31:0]        prdata_o,
  input logic [NUM_SRC-1:0] irq_src_i,
  input logic               irq_o
);
  localparam logic [63:0] IMPL = (NUM_SRC >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                 : ((64'd1 << NUM_SRC) - 64'd1);
  logic [31:0] a;
  logic [63:0] src_ext;
  logic        rd, mapped;

  always_comb begin
    a       = 32'(paddr_i);
    src_ext = 64'(irq_src_i);
    rd      = psel_i & ~pwrite_i;
    mapped  = (a == 32'h00) || (a == 32'h04) || (a == 32'h08) ||
              (a == 32'h0C) || (a == 32'h30) || (a == 32'h34);
  end

  a_r6_idle_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|irq_src_i) |=> !irq_o);

  a_r5_stat_lo_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a == 32'h30) |-> ((prdata_o & ~src_ext[31:0]) == 32'h0));

  a_r5_stat_hi_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a == 32'h34) |-> ((prdata_o & ~src_ext[63:32]) == 32'h0));

  a_r4_unimpl_lo_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (a == 32'h00 || a == 32'h08)) |-> ((prdata_o & ~IMPL[31:0]) == 32'h0));

  a_r9_unimpl_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (a == 32'h04 || a == 32'h0C)) |-> ((prdata_o & ~IMPL[63:32]) == 32'h0));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |-> (prdata_o == 32'h0));
endmodule

bind irq_aggr_apb irq_aggr_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .prdata_o (prdata_o),
  .irq_src_i(irq_src_i),
  .irq_o    (irq_o)
);

// File: tb/irq_aggr_apb_tb_top.sv
module irq_aggr_apb_tb_top;
  localparam int NB = 40;
  localparam int NS = 20;
  localparam logic [63:0] IMPL_B = (64'd1 << NB) - 64'd1;
  localparam logic [63:0] IMPL_S = (64'd1 << NS) - 64'd1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [63:0] src_v = '0;
  logic [31:0] prdata_b, prdata_s;
  logic        pready_b, pslverr_b, pready_s, pslverr_s;
  logic        irq_b, irq_s;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // model state
  logic [63:0] m_en = '0, m_msk = '0;
  logic        exp_b = 1'b0, exp_s = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_aggr_apb #(.NUM_SRC(NB), .ADDR_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata_b),
    .pready_o(pready_b), .pslverr_o(pslverr_b), .irq_src_i(src_v[NB-1:0]),
    .irq_o(irq_b));

  irq_aggr_apb #(.NUM_SRC(NS), .ADDR_W(8)) dut_small_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata_s),
    .pready_o(pready_s), .pslverr_o(pslverr_s), .irq_src_i(src_v[NS-1:0]),
    .irq_o(irq_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] a, input logic [63:0] impl);
    logic [63:0] e, m, st;
    e  = m_en & impl;
    m  = m_msk & impl;
    st = src_v & e & ~m & impl;
    case (a)
      8'h00:   return e[31:0];
      8'h04:   return e[63:32];
      8'h08:   return m[31:0];
      8'h0C:   return m[63:32];
      8'h30:   return st[31:0];
      8'h34:   return st[63:32];
      default: return 32'h0;
    endcase
  endfunction

  // reference model: irq from values before this edge, then apply write
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = '0; m_msk = '0; exp_b = 1'b0; exp_s = 1'b0;
    end else begin
      exp_b = |(src_v & m_en & ~m_msk & IMPL_B);
      exp_s = |(src_v & m_en & ~m_msk & IMPL_S);
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h00: m_en[31:0]   = pwdata;
          8'h04: m_en[63:32]  = pwdata;
          8'h08: m_msk[31:0]  = pwdata;
          8'h0C: m_msk[63:32] = pwdata;
          default: ;
        endcase
      end
    end
  end

  // R6: merged output compared every cycle
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R6 irq big", {31'b0, irq_b}, {31'b0, exp_b});
      chk("R6 irq small", {31'b0, irq_s}, {31'b0, exp_s});
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk_i);
    penable = 1'b1;
    @(negedge clk_i);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input string tag);
    @(negedge clk_i);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #2;
    chk({tag, " R8 setup-phase data"}, prdata_b, model_rd(a, IMPL_B));
    @(negedge clk_i);
    penable = 1'b1;
    #2;
    chk({tag, " big"}, prdata_b, model_rd(a, IMPL_B));
    chk({tag, " small"}, prdata_s, model_rd(a, IMPL_S));
    chk("R8 ready/err", {30'b0, pready_b & pready_s, pslverr_b | pslverr_s}, 32'h2);
    @(negedge clk_i);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    apb_rd(8'h00, tag); apb_rd(8'h04, tag); apb_rd(8'h08, tag);
    apb_rd(8'h0C, tag); apb_rd(8'h30, tag); apb_rd(8'h34, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq_b | irq_s}, 32'h0);
    rd_all("R1");

    // R2 R4 R9 enables all ones
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd(8'h00, "R2 en lo");
    apb_rd(8'h04, "R4 R9 en hi unimpl");
    chk("R4 en hi value", 32'h0000_00FF, model_rd(8'h04, IMPL_B));

    // R3 mask all ones, lines active but blocked
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_wr(8'h0C, 32'hFFFF_FFFF);
    apb_rd(8'h08, "R3 msk lo");
    apb_rd(8'h0C, "R3 R4 R9 msk hi");
    @(negedge clk_i); src_v = 64'h00FF_FFFF_FFFF;
    apb_rd(8'h30, "R5 masked lo");
    apb_rd(8'h34, "R5 masked hi");

    // R2 R3 partial patterns
    apb_wr(8'h00, 32'hA5A5_0F0F);
    apb_wr(8'h08, 32'h0000_FFFF);
    apb_rd(8'h00, "R2 pattern");
    apb_rd(8'h08, "R3 pattern");
    apb_rd(8'h30, "R5 gated lo");
    apb_wr(8'h0C, 32'h0000_0000);
    apb_wr(8'h04, 32'h0000_0088);
    apb_rd(8'h34, "R5 gated hi");

    // R6 latency with a single line
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_wr(8'h08, 32'h0);
    apb_wr(8'h04, 32'h0);
    @(negedge clk_i); src_v = '0;
    @(negedge clk_i); src_v = 64'h4;
    #1 chk("R6 not yet high", {31'b0, irq_b}, 32'h0);
    @(negedge clk_i);
    chk("R6 high next cycle", {31'b0, irq_b & irq_s}, 32'h1);
    apb_rd(8'h30, "R5 single lo");

    // R5 level follows, high-word line only on big
    @(negedge clk_i); src_v = 64'h0000_0008_0000_0000;
    apb_wr(8'h04, 32'h0000_0008);
    apb_rd(8'h34, "R5 line 35");
    apb_rd(8'h30, "R5 lo cleared");
    @(negedge clk_i); src_v = '0;
    apb_rd(8'h34, "R5 level drop");

    // R7 unmapped and misaligned
    apb_wr(8'h10, 32'hFFFF_FFFF);
    apb_wr(8'h01, 32'h0);
    apb_wr(8'h2C, 32'hFFFF_FFFF);
    apb_rd(8'h10, "R7 unmapped");
    apb_rd(8'h38, "R7 unmapped hi");
    apb_rd(8'h09, "R7 misaligned");
    apb_rd(8'h00, "R7 en untouched");
    apb_rd(8'h08, "R7 msk untouched");
    chk("R7 en value", model_rd(8'h00, IMPL_B), 32'hFFFF_FFFF);

    // R9 small instance high word with active line 35
    @(negedge clk_i); src_v = 64'hFFFF_FFFF_FFFF_FFFF;
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd(8'h34, "R9 stat hi");
    apb_rd(8'h04, "R9 en hi");
    @(negedge clk_i); src_v = '0;
    repeat (3) @(negedge clk_i);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule